// File: doc/BRIEF.md
# Bidirectional latched bus transceiver

This block sits between two eight-bit buses, called port A and port B, and carries data both ways through two separate storage stages. One stage takes data from port A and presents it toward port B. The other takes data from port B and presents it toward port A. Each direction has three active-low controls of its own: a select that qualifies everything in that direction, a latch control that makes the stage follow its input while low, and a drive control that lets the stage place its contents on the far port.

Each port appears as a data input, a data output and a one-bit drive enable, so the three-state pad stays outside the block. Transparency is a combinational pass-through from input to output. On each clock edge where the stage is transparent, the storage register samples the input. When the latch control rises, the stage therefore keeps the value that was present at the last edge while it was low. The block also flags contention. This happens when it would drive a port that the opposite direction is reading through a transparent stage, which would close a loop through the pads.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero. While reset is high, a_oe and b_oe are 0. After reset, with the selects low and the latch controls high, a_out and b_out read 0.
- R2: When ab_sel_n=0 and ab_lat_n=0, the A-to-B stage is transparent and b_out equals a_in in the same cycle, with no clock edge in between.
- R3: On each clock edge where the A-to-B stage is transparent, its storage takes a_in. Once ab_lat_n is 1, b_out keeps the value of a_in from the last such edge, whatever a_in does.
- R4: When ab_sel_n=1, the A-to-B storage keeps its contents across clock edges whatever ab_lat_n and a_in do. Whenever the stage is not transparent, b_out shows the stored contents, whatever the drive controls are.
- R5: b_oe is 1 exactly when reset is low, ab_sel_n=0 and ab_drv_n=0. a_oe is 1 exactly when reset is low, ba_sel_n=0 and ba_drv_n=0.
- R6: The B-to-A stage follows R2 to R4 with b_in, a_out, ba_sel_n and ba_lat_n in place of the A-to-B signals.
- R7: The two directions are independent. Loading or holding one stage leaves the other stage's stored value and output unchanged.
- R8: contention is 1 exactly when (b_oe=1 and the B-to-A stage is transparent) or (a_oe=1 and the A-to-B stage is transparent).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Data arriving from port A |
| b_in | input | 8 | Data arriving from port B |
| ab_sel_n | input | 1 | A-to-B select, active low |
| ab_lat_n | input | 1 | A-to-B latch control, low means transparent |
| ab_drv_n | input | 1 | A-to-B drive control, active low |
| ba_sel_n | input | 1 | B-to-A select, active low |
| ba_lat_n | input | 1 | B-to-A latch control, low means transparent |
| ba_drv_n | input | 1 | B-to-A drive control, active low |
| b_out | output | 8 | Data presented toward port B |
| b_oe | output | 1 | Drive enable for the port B pad |
| a_out | output | 8 | Data presented toward port A |
| a_oe | output | 1 | Drive enable for the port A pad |
| contention | output | 1 | Drive collides with an opposite transparent stage |

## Verification
The assertions check on every cycle that both outputs read zero right after reset. They check that a stage which was transparent at one edge and is closed at the next shows the input sampled at that edge, and that a closed stage keeps its output stable. They also check that no drive enable is asserted without its direction selected or while reset is high, and that contention is only raised while some port is driven. Only the bench scenarios can show the same-cycle pass-through, the full sweep of the three controls per direction, the independence of the two stages and the exact conditions that set or clear the contention flag.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Control bundle for one direction, all active low.
  typedef struct packed {
    logic sel_n;
    logic lat_n;
    logic drv_n;
  } dir_ctl_t;

  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;
endpackage

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  dir_ctl_t         ctl,
  output logic [WIDTH-1:0] dout,
  output logic             drive,
  output logic             transp
);
  logic [WIDTH-1:0] store_q;
  logic             selected;

  assign selected = ~ctl.sel_n;
  assign transp   = selected & ~ctl.lat_n;

  // Storage samples its input at every edge while transparent.
  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (transp) begin
      store_q <= din;
    end
  end

  assign dout  = transp ? din : store_q;
  assign drive = ~rst & selected & ~ctl.drv_n;
endmodule

// File: rtl/xcvr_hazard.sv
`timescale 1ns/1ps
module xcvr_hazard
  import xcvr_pkg::*;
#(
  parameter int NDIR = NUM_DIR
) (
  input  logic [NDIR-1:0] drive,
  input  logic [NDIR-1:0] transp,
  output logic            flag
);
  // Direction d drives the port that direction (NDIR-1-d) reads from.
  logic [NDIR-1:0] hit;
  for (genvar d = 0; d < NDIR; d++) begin : g_hit
    assign hit[d] = drive[d] & transp[NDIR-1-d];
  end
  assign flag = |hit;
endmodule

// File: rtl/bidir_latch_xcvr.sv
`timescale 1ns/1ps
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_sel_n,
  input  logic             ab_lat_n,
  input  logic             ab_drv_n,
  input  logic             ba_sel_n,
  input  logic             ba_lat_n,
  input  logic             ba_drv_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic             contention
);
  logic [WIDTH-1:0]   src [NUM_DIR];
  logic [WIDTH-1:0]   dst [NUM_DIR];
  dir_ctl_t           ctl [NUM_DIR];
  logic [NUM_DIR-1:0] drv;
  logic [NUM_DIR-1:0] trn;

  assign src[DIR_AB] = a_in;
  assign src[DIR_BA] = b_in;
  assign ctl[DIR_AB] = '{sel_n: ab_sel_n, lat_n: ab_lat_n, drv_n: ab_drv_n};
  assign ctl[DIR_BA] = '{sel_n: ba_sel_n, lat_n: ba_lat_n, drv_n: ba_drv_n};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_lane #(.WIDTH(WIDTH)) i_lane (
      .clk    (clk),
      .rst    (rst),
      .din    (src[d]),
      .ctl    (ctl[d]),
      .dout   (dst[d]),
      .drive  (drv[d]),
      .transp (trn[d])
    );
  end

  xcvr_hazard #(.NDIR(NUM_DIR)) i_hazard (
    .drive  (drv),
    .transp (trn),
    .flag   (contention)
  );

  assign b_out = dst[DIR_AB];
  assign b_oe  = drv[DIR_AB];
  assign a_out = dst[DIR_BA];
  assign a_oe  = drv[DIR_BA];
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             ab_sel_n,
  input logic             ab_lat_n,
  input logic             ab_drv_n,
  input logic             ba_sel_n,
  input logic             ba_lat_n,
  input logic             ba_drv_n,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic             contention
);
  a_r1_clear_ab: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && (ab_sel_n || ab_lat_n)) |-> (b_out == '0));
  a_r1_clear_ba: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && (ba_sel_n || ba_lat_n)) |-> (a_out == '0));

  a_r3_capture_ab: assert property (@(posedge clk) disable iff (rst)
    (!ab_sel_n && !ab_lat_n) |=> ((ab_sel_n || ab_lat_n) -> (b_out == $past(a_in))));
  a_r6_capture_ba: assert property (@(posedge clk) disable iff (rst)
    (!ba_sel_n && !ba_lat_n) |=> ((ba_sel_n || ba_lat_n) -> (a_out == $past(b_in))));

  a_r4_hold_ab: assert property (@(posedge clk) disable iff (rst)
    (ab_sel_n || ab_lat_n) |=> ((ab_sel_n || ab_lat_n) -> $stable(b_out)));
  a_r6_hold_ba: assert property (@(posedge clk) disable iff (rst)
    (ba_sel_n || ba_lat_n) |=> ((ba_sel_n || ba_lat_n) -> $stable(a_out)));

  a_r5_boe_needs_sel: assert property (@(posedge clk)
    b_oe |-> (!rst && !ab_sel_n && !ab_drv_n));
  a_r5_aoe_needs_sel: assert property (@(posedge clk)
    a_oe |-> (!rst && !ba_sel_n && !ba_drv_n));

  a_r8_flag_needs_drive: assert property (@(posedge clk) disable iff (rst)
    contention |-> (a_oe || b_oe));
endmodule

bind bidir_latch_xcvr xcvr_checker #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
  .ab_sel_n(ab_sel_n), .ab_lat_n(ab_lat_n), .ab_drv_n(ab_drv_n),
  .ba_sel_n(ba_sel_n), .ba_lat_n(ba_lat_n), .ba_drv_n(ba_drv_n),
  .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
  .contention(contention)
);

// File: tb/test_bidir_latch_xcvr.sv
`timescale 1ns/1ps
module test_bidir_latch_xcvr;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_sel_n = 1'b0, ab_lat_n = 1'b1, ab_drv_n = 1'b0;
  logic ba_sel_n = 1'b0, ba_lat_n = 1'b1, ba_drv_n = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic         b_oe, a_oe, contention;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  bidir_latch_xcvr #(.WIDTH(W)) i_bidir_latch_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_sel_n(ab_sel_n), .ab_lat_n(ab_lat_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_lat_n(ba_lat_n), .ba_drv_n(ba_drv_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
    .contention(contention)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance one edge; inputs change just after the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic set_ab(input logic s, input logic l, input logic d);
    ab_sel_n = s; ab_lat_n = l; ab_drv_n = d;
  endtask

  task automatic set_ba(input logic s, input logic l, input logic d);
    ba_sel_n = s; ba_lat_n = l; ba_drv_n = d;
  endtask

  task automatic load_ab(input logic [W-1:0] v);
    set_ab(1'b0, 1'b0, 1'b1); a_in = v; step();
    ab_lat_n = 1'b1;
  endtask

  task automatic load_ba(input logic [W-1:0] v);
    set_ba(1'b0, 1'b0, 1'b1); b_in = v; step();
    ba_lat_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    a_in = 8'hFF; b_in = 8'hEE;
    set_ab(1'b0, 1'b0, 1'b0); set_ba(1'b0, 1'b0, 1'b0);
    step(); settle();
    check("R1 b_oe low in reset", b_oe, 0);
    check("R1 a_oe low in reset", a_oe, 0);
    check("R8 no flag in reset", contention, 0);
    set_ab(1'b0, 1'b1, 1'b0); set_ba(1'b0, 1'b1, 1'b0);
    step();
    rst = 1'b0;
    step(); settle();
    check("R1 b_out cleared", b_out, 0);
    check("R1 a_out cleared", a_out, 0);
  endtask

  task automatic t_pass_latch_ab();
    set_ba(1'b1, 1'b1, 1'b1);
    set_ab(1'b0, 1'b0, 1'b0); a_in = 8'h11; settle();
    check("R2 pass-through same cycle", b_out, 8'h11);
    a_in = 8'h5A; settle();
    check("R2 follows a_in without edge", b_out, 8'h5A);
    step();
    a_in = 8'h22; settle();
    check("R2 still transparent", b_out, 8'h22);
    step();
    ab_lat_n = 1'b1; a_in = 8'h33; settle();
    check("R3 latched last sampled", b_out, 8'h22);
    step();
    a_in = 8'h44; settle();
    check("R3 ignores a_in after latch", b_out, 8'h22);
    check("R5 b_oe driven", b_oe, 1);
  endtask

  task automatic t_pass_latch_ba();
    set_ab(1'b1, 1'b1, 1'b1);
    set_ba(1'b0, 1'b0, 1'b0); b_in = 8'h81; settle();
    check("R6 pass-through B to A", a_out, 8'h81);
    step();
    b_in = 8'h92; step();
    ba_lat_n = 1'b1; b_in = 8'h07; settle();
    check("R6 latched last sampled", a_out, 8'h92);
    step(); settle();
    check("R6 holds after edge", a_out, 8'h92);
    check("R5 a_oe driven", a_oe, 1);
  endtask

  task automatic t_hold_sel();
    load_ab(8'hC3);
    set_ab(1'b1, 1'b0, 1'b0); a_in = 8'h3C;
    step(); step(); settle();
    check("R4 b_oe off while deselected", b_oe, 0);
    check("R4 b_out shows store while deselected", b_out, 8'hC3);
    set_ab(1'b0, 1'b1, 1'b0); settle();
    check("R4 store kept while deselected", b_out, 8'hC3);
  endtask

  // Every combination of the three controls in each direction.
  task automatic t_sweep();
    for (int dir = 0; dir < 2; dir++) begin
      for (int c = 0; c < 8; c++) begin
        logic s, l, d, tr;
        logic [W-1:0] got;
        s = c[2]; l = c[1]; d = c[0];
        tr = !s && !l;
        if (dir == 0) begin
          set_ba(1'b1, 1'b1, 1'b1); load_ab(8'h3C);
          set_ab(s, l, d); a_in = 8'hA5; settle();
          check("R5 sweep b_oe", b_oe, !s && !d);
          check("R2 sweep b_out now", b_out, tr ? 8'hA5 : 8'h3C);
          step(); a_in = 8'h0F; settle(); got = b_out;
        end else begin
          set_ab(1'b1, 1'b1, 1'b1); load_ba(8'h3C);
          set_ba(s, l, d); b_in = 8'hA5; settle();
          check("R5 sweep a_oe", a_oe, !s && !d);
          check("R6 sweep a_out now", a_out, tr ? 8'hA5 : 8'h3C);
          step(); b_in = 8'h0F; settle(); got = a_out;
        end
        check("R4 sweep after edge", got, tr ? 8'h0F : 8'h3C);
      end
    end
  endtask

  task automatic t_independent();
    load_ab(8'h12);
    load_ba(8'h34);
    set_ba(1'b0, 1'b1, 1'b0);
    set_ab(1'b0, 1'b0, 1'b1); a_in = 8'h99;
    step(); step(); settle();
    check("R7 B-to-A unaffected by A-to-B load", a_out, 8'h34);
    set_ab(1'b0, 1'b1, 1'b0);
    set_ba(1'b0, 1'b0, 1'b1); b_in = 8'h77;
    step(); ba_lat_n = 1'b1; settle();
    check("R7 A-to-B unaffected by B-to-A load", b_out, 8'h99);
    check("R7 B-to-A took its own value", a_out, 8'h77);
  endtask

  task automatic t_contention();
    set_ab(1'b0, 1'b1, 1'b0); set_ba(1'b0, 1'b0, 1'b1); settle();
    check("R8 B driven while B-to-A transparent", contention, 1);
    set_ba(1'b0, 1'b1, 1'b1); settle();
    check("R8 clear when B-to-A latched", contention, 0);
    set_ab(1'b0, 1'b0, 1'b1); set_ba(1'b0, 1'b1, 1'b0); settle();
    check("R8 A driven while A-to-B transparent", contention, 1);
    set_ba(1'b1, 1'b1, 1'b0); settle();
    check("R8 clear when A not driven", contention, 0);
    set_ab(1'b0, 1'b0, 1'b0); set_ba(1'b0, 1'b0, 1'b0); settle();
    check("R8 both loops", contention, 1);
    set_ab(1'b1, 1'b1, 1'b1); set_ba(1'b1, 1'b1, 1'b1); step();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_pass_latch_ab();
    t_pass_latch_ba();
    t_hold_sel();
    t_sweep();
    t_independent();
    t_contention();
    summary();
  end

  initial begin
    #500us;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end
endmodule